// File: doc/BRIEF.md
# Pixel Word Assembler

This block takes the words arriving on a 16-bit pixel port and turns them into a stream of display pixels. Each pixel is either a 24-bit colour triple or an 8-bit palette index. The block runs on a fast dot clock. A pixel-clock enable marks the dot-clock edges on which the port is sampled. On such an edge the port data, the active-high display-enable (blank) input and the mode-mix input are all taken in.

Two mode registers sit at the inputs: a primary mode and a secondary mode. The mix input picks between them one pixel at a time. A mode can need one, two or three port words per output. Words are gathered least significant first, and word alignment is restarted by every blanked sample. This means the first word taken after blank rises is always word one of a pixel.

Two modes produce two pixels per group. In the double-index mode, one 16-bit word carries two indices. In the packed mode, three words carry two colour pixels. The second pixel of such a group leaves one dot clock after the first. A blanked sample produces a zero pixel marked inactive. An unsupported mode code produces a zero pixel and sets a sticky error flag.

Top module: `pixel_word_assembler`

## Requirements
- R1: After reset, out_valid, out_active and mode_err are 0.
- R2: The port is sampled only on a clk edge with pclk_en high, and the resulting pixel is on the outputs right after that edge. Samples must be at least two clk cycles apart. In every clk cycle in which nothing is sampled and no second pixel is pending, out_valid is 0.
- R3: A sample with blank_n low produces one output beat with out_valid=1, out_active=0, and colour and index all zero. It also restarts word alignment, so the next sample with blank_n high is the first word of a pixel.
- R4: Mode code 0 (single index) uses one word. out_index = pix_in[7:0], and the colour outputs are zero.
- R5: Mode code 1 (5-6-5 word) uses one word. Red = {pix_in[15:11],000}, green = {pix_in[10:5],00}, blue = {pix_in[4:0],000}, and out_index = 0.
- R6: Mode code 2 (24-bit over the low byte) uses three words, whose low bytes carry blue, then green, then red. No pixel is output before the third word.
- R7: Mode code 3 (5-6-5 over two bytes) uses two words. The first low byte holds {G4..G2, B7..B3}. The second low byte holds {R7..R3, G7..G5}. Colour bits not carried are zero.
- R8: Mode code 4 (double index) uses one word and outputs two pixels: index pix_in[7:0] right after the sampling edge, then index pix_in[15:8] one clk later.
- R9: Mode code 5 (packed 24-bit) uses three words for two pixels. Word 1 is {G1,B1}, word 2 is {B2,R1}, and word 3 is {R2,G2}, with the high byte written first. Pixel 1 is output after word 3, and pixel 2 one clk later.
- R10: mix_sel=0 selects mode_pri and mix_sel=1 selects mode_sec. Both mix_sel and the mode inputs are taken only on the first word of a pixel, so a change later in the same group has no effect on that group.
- R11: Mode codes 6 to 15 are unsupported. Each blank-high sample then outputs a zero pixel with out_active=1 and sets mode_err. mode_err stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_en | input | 1 | Pixel-clock enable; port sampled when high |
| pix_in | input | 16 | Pixel port word |
| blank_n | input | 1 | High during active display |
| mix_sel | input | 1 | 0 selects primary mode, 1 selects secondary mode |
| mode_pri | input | 4 | Primary mode code |
| mode_sec | input | 4 | Secondary mode code |
| out_valid | output | 1 | A pixel is on the outputs this cycle |
| out_active | output | 1 | Pixel is display data, not blanking |
| out_red | output | 8 | Red component |
| out_grn | output | 8 | Green component |
| out_blu | output | 8 | Blue component |
| out_index | output | 8 | Palette index for index modes |
| mode_err | output | 1 | Sticky unsupported-mode flag |

## Verification
The functions that can coincide are the mode choice and group completion. A mix or mode-register change can land on the same word that completes a multi-word group. The bench provokes this by toggling mix_sel on the second word of a group, in both directions, between a two-word and a three-word mode. The judgement is the group length and the colour layout of the emitted pixel, which must follow the mode chosen on the first word. A blanked sample that falls inside a group is also checked: the following group must come out aligned.

// File: rtl/pxa_pkg.sv
package pxa_pkg;
  localparam int PORT_W  = 16;
  localparam int COLOR_W = 8;
  localparam int MODE_W  = 4;
  localparam int MAX_WORDS = 3;
  localparam int CNT_W   = $clog2(MAX_WORDS + 1);

  localparam logic [MODE_W-1:0] M_IDX1   = 4'd0;
  localparam logic [MODE_W-1:0] M_W565   = 4'd1;
  localparam logic [MODE_W-1:0] M_B888   = 4'd2;
  localparam logic [MODE_W-1:0] M_B565   = 4'd3;
  localparam logic [MODE_W-1:0] M_IDX2   = 4'd4;
  localparam logic [MODE_W-1:0] M_PACK24 = 4'd5;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic [COLOR_W-1:0] idx;
  } pix_t;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    return m <= M_PACK24;
  endfunction

  // Words per group; unsupported codes consume one word each.
  function automatic logic [CNT_W-1:0] words_of(input logic [MODE_W-1:0] m);
    case (m)
      M_B888, M_PACK24: return CNT_W'(3);
      M_B565:           return CNT_W'(2);
      default:          return CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/pxa_mode_sel.sv
module pxa_mode_sel
  import pxa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              first,
  input  logic              mix,
  input  logic [MODE_W-1:0] pri,
  input  logic [MODE_W-1:0] sec,
  output logic [MODE_W-1:0] cur_mode
);
  logic [MODE_W-1:0] fresh;
  logic [MODE_W-1:0] held;

  assign fresh    = mix ? sec : pri;
  assign cur_mode = first ? fresh : held;

  always_ff @(posedge clk) begin
    if (rst)               held <= '0;
    else if (take && first) held <= fresh;
  end

  // R10: the held mode only moves on the first word of a group
  p_hold_mid_group_r10: assert property (@(posedge clk) disable iff (rst)
    (!first) |=> $stable(held))
    else $error("held mode changed inside a group");
endmodule

// File: rtl/pxa_gather.sv
module pxa_gather
  import pxa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pclk_en,
  input  logic              blank_n,
  input  logic [CNT_W-1:0]  need,
  input  logic [PORT_W-1:0] word,
  output logic              first,
  output logic              done,
  output logic [PORT_W-1:0] w0,
  output logic [PORT_W-1:0] w1
);
  logic [CNT_W-1:0] cnt;

  assign first = (cnt == '0);
  assign done  = pclk_en && blank_n && (cnt == need - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      w0  <= '0;
      w1  <= '0;
    end else if (pclk_en) begin
      if (!blank_n || done) begin
        cnt <= '0;
      end else begin
        if (first) w0 <= word;
        else       w1 <= word;
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R3: a blanked sample realigns so the next word is a first word
  p_align_r3: assert property (@(posedge clk) disable iff (rst)
    (pclk_en && !blank_n) |=> first)
    else $error("alignment not restarted by blank");

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(MAX_WORDS))
    else $error("word counter out of range");
endmodule

// File: rtl/pxa_unpack.sv
module pxa_unpack
  import pxa_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [PORT_W-1:0] w0,
  input  logic [PORT_W-1:0] w1,
  input  logic [PORT_W-1:0] cur,
  output pix_t              pa,
  output pix_t              pb,
  output logic              two
);
  always_comb begin
    pa  = '0;
    pb  = '0;
    two = 1'b0;
    case (mode)
      M_IDX1: pa.idx = cur[7:0];
      M_W565: begin
        pa.r = {cur[15:11], 3'b000};
        pa.g = {cur[10:5], 2'b00};
        pa.b = {cur[4:0], 3'b000};
      end
      M_B888: begin
        pa.b = w0[7:0];
        pa.g = w1[7:0];
        pa.r = cur[7:0];
      end
      M_B565: begin
        pa.b = {w0[4:0], 3'b000};
        pa.g = {cur[2:0], w0[7:5], 2'b00};
        pa.r = {cur[7:3], 3'b000};
      end
      M_IDX2: begin
        pa.idx = cur[7:0];
        pb.idx = cur[15:8];
        two    = 1'b1;
      end
      M_PACK24: begin
        pa.b = w0[7:0];
        pa.g = w0[15:8];
        pa.r = w1[7:0];
        pb.b = w1[15:8];
        pb.g = cur[7:0];
        pb.r = cur[15:8];
        two  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pixel_word_assembler.sv
module pixel_word_assembler
  import pxa_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pclk_en,
  input  logic [PORT_W-1:0]  pix_in,
  input  logic               blank_n,
  input  logic               mix_sel,
  input  logic [MODE_W-1:0]  mode_pri,
  input  logic [MODE_W-1:0]  mode_sec,
  output logic               out_valid,
  output logic               out_active,
  output logic [COLOR_W-1:0] out_red,
  output logic [COLOR_W-1:0] out_grn,
  output logic [COLOR_W-1:0] out_blu,
  output logic [COLOR_W-1:0] out_index,
  output logic               mode_err
);
  logic              first, done, two, ok;
  logic [MODE_W-1:0] cur_mode;
  logic [CNT_W-1:0]  need;
  logic [PORT_W-1:0] w0, w1;
  pix_t              pa, pb, pix_q, hold;
  logic              hold_v;

  assign ok   = mode_ok(cur_mode);
  assign need = words_of(cur_mode);

  pxa_mode_sel u_sel (
    .clk(clk), .rst(rst), .take(pclk_en && blank_n), .first(first),
    .mix(mix_sel), .pri(mode_pri), .sec(mode_sec), .cur_mode(cur_mode)
  );

  pxa_gather u_gather (
    .clk(clk), .rst(rst), .pclk_en(pclk_en), .blank_n(blank_n),
    .need(need), .word(pix_in), .first(first), .done(done),
    .w0(w0), .w1(w1)
  );

  pxa_unpack u_unpack (
    .mode(cur_mode), .w0(w0), .w1(w1), .cur(pix_in),
    .pa(pa), .pb(pb), .two(two)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_active <= 1'b0;
      pix_q      <= '0;
      hold       <= '0;
      hold_v     <= 1'b0;
      mode_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (pclk_en) begin
        if (!blank_n) begin
          out_valid  <= 1'b1;
          out_active <= 1'b0;
          pix_q      <= '0;
        end else if (!ok) begin
          out_valid  <= 1'b1;
          out_active <= 1'b1;
          pix_q      <= '0;
          mode_err   <= 1'b1;
        end else if (done) begin
          out_valid  <= 1'b1;
          out_active <= 1'b1;
          pix_q      <= pa;
          hold       <= pb;
          hold_v     <= two;
        end
      end else if (hold_v) begin
        out_valid  <= 1'b1;
        out_active <= 1'b1;
        pix_q      <= hold;
        hold_v     <= 1'b0;
      end
    end
  end

  assign out_red   = pix_q.r;
  assign out_grn   = pix_q.g;
  assign out_blu   = pix_q.b;
  assign out_index = pix_q.idx;

  p_blank_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (pclk_en && !blank_n) |=> (out_valid && !out_active && out_red == '0 &&
      out_grn == '0 && out_blu == '0 && out_index == '0))
    else $error("blanked sample not zero");

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    mode_err |=> mode_err)
    else $error("error flag cleared without reset");

  p_dot_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    hold_v |-> !pclk_en)
    else $error("sample arrived while second pixel pending");

  p_second_pixel_r8: assert property (@(posedge clk) disable iff (rst)
    hold_v |=> (out_valid && out_active))
    else $error("second pixel not emitted");

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!pclk_en && !hold_v) |=> !out_valid)
    else $error("output without a sample");
endmodule

// File: tb/sim_pixel_word_assembler.sv
module sim_pixel_word_assembler;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1, pclk_en = 1'b0, blank_n = 1'b0, mix = 1'b0;
  logic [15:0] pix = '0;
  logic [3:0] mp = '0, ms = '0;
  logic out_valid, out_active, mode_err;
  logic [7:0] out_red, out_grn, out_blu, out_index;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic v1, a1, v2, a2;
  logic [7:0] r1, g1, b1, x1, r2, g2, b2, x2;

  pixel_word_assembler u0 (
    .clk(clk), .rst(rst), .pclk_en(pclk_en), .pix_in(pix), .blank_n(blank_n),
    .mix_sel(mix), .mode_pri(mp), .mode_sec(ms), .out_valid(out_valid),
    .out_active(out_active), .out_red(out_red), .out_grn(out_grn),
    .out_blu(out_blu), .out_index(out_index), .mode_err(mode_err)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [15:0] d, input logic bn, input logic mx);
    @(negedge clk);
    pix = d; blank_n = bn; mix = mx; pclk_en = 1'b1;
    @(negedge clk);
    pclk_en = 1'b0;
    v1 = out_valid; a1 = out_active; r1 = out_red; g1 = out_grn; b1 = out_blu; x1 = out_index;
    @(negedge clk);
    v2 = out_valid; a2 = out_active; r2 = out_red; g2 = out_grn; b2 = out_blu; x2 = out_index;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog got hung exp finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 valid", out_valid, 0);
    chk("R1 active", out_active, 0);
    chk("R1 err", mode_err, 0);

    // R3 blanked sample
    send(16'hFFFF, 1'b0, 1'b0);
    chk("R3 blank valid", {v1, a1}, 2'b10);
    chk("R3 blank data", {r1, g1, b1, x1}, 32'h0);

    // R4 single index
    mp = 4'd0; ms = 4'd0;
    for (int i = 0; i < 32; i++) begin
      logic [15:0] d;
      d = 16'(i * 2053 + 17);
      send(d, 1'b1, 1'b0);
      chk("R4 valid", {v1, a1}, 2'b11);
      chk("R4 index", {r1, g1, b1, x1}, {24'h0, d[7:0]});
      chk("R2 no extra pixel", v2, 0);
    end

    // R5 5-6-5 word
    mp = 4'd1;
    for (int i = 0; i < 32; i++) begin
      logic [15:0] d;
      logic [7:0] er, eg, eb;
      d = 16'(i * 4099) ^ 16'hA5C3;
      er = 8'((d >> 11) * 8);
      eg = 8'(((d >> 5) % 64) * 4);
      eb = 8'((d % 32) * 8);
      send(d, 1'b1, 1'b0);
      chk("R5 rgb", {r1, g1, b1, x1}, {er, eg, eb, 8'h0});
    end

    // R6 24-bit over low byte
    mp = 4'd2;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] eb, eg, er;
      eb = 8'(i * 17); eg = 8'(255 - i * 9); er = 8'(i * 29 + 3);
      send({8'h5A, eb}, 1'b1, 1'b0);
      chk("R6 none after word1", v1, 0);
      send({8'hC3, eg}, 1'b1, 1'b0);
      chk("R6 none after word2", v1, 0);
      send({8'h0F, er}, 1'b1, 1'b0);
      chk("R6 rgb", {v1, r1, g1, b1}, {1'b1, er, eg, eb});
    end

    // R7 5-6-5 over two bytes
    mp = 4'd3;
    for (int i = 0; i < 16; i++) begin
      logic [4:0] rr, bb;
      logic [5:0] gg;
      rr = 5'(i * 2 + 1); gg = 6'(i * 5 + 2); bb = 5'(31 - i);
      send({8'h77, gg[2:0], bb}, 1'b1, 1'b0);
      chk("R7 none after byte1", v1, 0);
      send({8'h99, rr, gg[5:3]}, 1'b1, 1'b0);
      chk("R7 rgb", {v1, r1, g1, b1}, {1'b1, rr, 3'b0, gg, 2'b0, bb, 3'b0});
    end

    // R8 double index
    mp = 4'd4;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] d;
      d = 16'(i * 3001 + 7);
      send(d, 1'b1, 1'b0);
      chk("R8 first", {v1, a1, x1}, {2'b11, d[7:0]});
      chk("R8 second", {v2, a2, x2}, {2'b11, d[15:8]});
    end

    // R9 packed 24-bit, two pixels in three words
    mp = 4'd5;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ra, ga, ba, rb, gb, bb;
      ra = 8'(i * 31 + 1); ga = 8'(i * 13 + 2); ba = 8'(i * 7 + 3);
      rb = 8'(200 - i * 11); gb = 8'(i * 37 + 5); bb = 8'(i * 19 + 9);
      send({ga, ba}, 1'b1, 1'b0);
      send({bb, ra}, 1'b1, 1'b0);
      chk("R9 none before word3", v1, 0);
      send({rb, gb}, 1'b1, 1'b0);
      chk("R9 pixel1", {v1, r1, g1, b1}, {1'b1, ra, ga, ba});
      chk("R9 pixel2", {v2, r2, g2, b2}, {1'b1, rb, gb, bb});
    end

    // R10 per-pixel switch between primary (index) and secondary (565 word)
    mp = 4'd0; ms = 4'd1;
    for (int i = 0; i < 8; i++) begin
      logic [15:0] d;
      d = 16'(i * 5381 + 99);
      send(d, 1'b1, 1'(i % 2));
      if (i % 2 == 0)
        chk("R10 primary", {r1, g1, b1, x1}, {24'h0, d[7:0]});
      else
        chk("R10 secondary", {r1, g1, b1, x1},
            {8'((d >> 11) * 8), 8'(((d >> 5) % 64) * 4), 8'((d % 32) * 8), 8'h0});
    end

    // R10 mix change mid group is ignored (two-byte primary, three-byte secondary)
    mp = 4'd3; ms = 4'd2;
    send(16'h00E5, 1'b1, 1'b0);
    send(16'h00A9, 1'b1, 1'b1);
    chk("R10 mid-group mix ignored", {v1, r1, g1, b1}, {1'b1, 8'hA8, 8'h3C, 8'h28});
    send(16'h0012, 1'b1, 1'b1);
    send(16'h0034, 1'b1, 1'b0);
    chk("R10 secondary held mid", v1, 0);
    send(16'h0056, 1'b1, 1'b0);
    chk("R10 secondary held", {v1, r1, g1, b1}, {1'b1, 8'h56, 8'h34, 8'h12});
    // mode input changed mid group is also ignored
    mp = 4'd3; ms = 4'd3;
    send(16'h00E5, 1'b1, 1'b0);
    mp = 4'd0;
    send(16'h00A9, 1'b1, 1'b0);
    chk("R10 mode reg mid-group", {v1, r1, g1, b1}, {1'b1, 8'hA8, 8'h3C, 8'h28});

    // R3 alignment restarted by blank inside a group
    mp = 4'd2;
    send(16'h00AA, 1'b1, 1'b0);
    send(16'h1234, 1'b0, 1'b0);
    chk("R3 blank mid-group", {v1, a1, r1, g1, b1, x1}, {2'b10, 32'h0});
    send(16'h0011, 1'b1, 1'b0);
    send(16'h0022, 1'b1, 1'b0);
    send(16'h0033, 1'b1, 1'b0);
    chk("R3 realigned group", {v1, r1, g1, b1}, {1'b1, 8'h33, 8'h22, 8'h11});

    // R11 unsupported codes
    for (int m = 6; m < 16; m++) begin
      mp = 4'(m);
      send(16'hBEEF, 1'b1, 1'b0);
      chk("R11 zero pixel", {v1, a1, r1, g1, b1, x1}, {2'b11, 32'h0});
      chk("R11 err set", mode_err, 1);
    end
    mp = 4'd0;
    send(16'h0042, 1'b1, 1'b0);
    chk("R11 err sticky", mode_err, 1);
    chk("R11 good mode after", x1, 8'h42);
    do_reset();
    chk("R1 err cleared", mode_err, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule